// File: doc/BRIEF.md
# Reloadable Down-Counting Timer

This block is a single-channel timer that sits behind a plain 32-bit register bus made up of an address, a write strobe, write data and combinational read data. Software loads a start count and a reload interval, picks a prescaler ratio and a mode, and sets the run bit. The counter then steps down by one on every prescaled tick. When it steps from one to zero it raises a sticky pending flag.

In periodic mode the counter loads the interval on the next tick and keeps running. In one-shot mode the hardware clears the run bit and the counter rests at zero. The start count and the interval are held in separate registers, so the first timeout can be shorter or longer than the ones that follow. The interrupt line is the pending flag masked by an enable bit.

A source-select bit is kept in the control register for software but does not change the timing. The mode bit is read only at the moment of expiry, so a mode change applies from the next timeout onward. A one-shot timer that has stopped is re-armed by writing a new count and setting the run bit again.

Top module: `reload_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The byte addresses are 0x00 for interrupt enable (bit 0), 0x04 for status (bit 0 is pending), 0x10 for control, 0x14 for the interval and 0x18 for the current count. The control fields are run at bit 0, periodic at bit 1, source select at bit 2 and prescaler exponent at bits 6:4. Unused control bits read as zero.
- R3: A write to an unmapped address changes no register, and a read from an unmapped address returns zero.
- R4: With prescaler exponent n, the counter steps once every 2^n clocks. After the control write that sets the run bit, the first step comes on the 2^n-th rising edge. Every control write restarts the prescaler.
- R5: While the run bit is set, each tick lowers a nonzero count by one. While the run bit is clear, the count holds.
- R6: A tick that takes the count from 1 to 0 sets the pending flag in the same edge, whether or not the interrupt is enabled.
- R7: In one-shot mode (periodic bit 0), expiry clears the run bit and the count stays at zero.
- R8: In periodic mode, the tick after the count reaches zero loads the interval. The first expiry is timed from the value written to the current-count register.
- R9: A write to the current-count register takes priority over a tick in the same cycle and leaves the interval unchanged.
- R10: Writing 1 to status bit 0 clears the pending flag. If an expiry happens in the same cycle, the flag stays set.
- R11: `irq` is high exactly when the pending flag and interrupt-enable bit 0 are both set.
- R12: The periodic bit is sampled at each expiry, so clearing it during a run stops the timer at the next timeout. A stopped timer restarts after a new count is written and the run bit is set.
- R13: The source-select bit reads back as written and does not change tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational from address) |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach is a status-clear write that lands in the very edge where a new expiry sets the flag again. The bench reaches it with a short periodic run: start count 2 and interval 3 give an expiry every four clocks. Because the bench knows the exact edge on which its write commits, it times the clear write to land on the second expiry. The same cycle counting is used to land a count write on a running tick and a mode change in the middle of a countdown.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int PRESC_W = 3;

  localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_IVAL = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CUR  = 8'h18;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic               run;
    logic               autoReload;
    logic [PRESC_W-1:0] divSel;
    logic               prescClr;
    logic               curWr;
    logic [DATA_W-1:0]  curData;
    logic [DATA_W-1:0]  interval;
  } ctrlToDp_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PRESC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlToDp_t     cmd,
  output logic [DW-1:0] curValue,
  output logic          expire
);
  localparam int CNT_W = (1 << PW) - 1;

  logic [CNT_W-1:0] prescCnt;
  logic [CNT_W-1:0] prescMask;
  logic             tick;

  assign prescMask = ~({CNT_W{1'b1}} << cmd.divSel);
  assign tick      = cmd.run && (prescCnt == prescMask);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.prescClr || !cmd.run) prescCnt <= '0;
    else if (prescCnt == prescMask)         prescCnt <= '0;
    else                                    prescCnt <= prescCnt + 1'b1;
  end

  assign expire = tick && !cmd.curWr && (curValue == DW'(1));

  always_ff @(posedge clk) begin
    if (!rstN)             curValue <= '0;
    else if (cmd.curWr)    curValue <= cmd.curData;
    else if (tick) begin
      if (curValue != '0)      curValue <= curValue - 1'b1;
      else if (cmd.autoReload) curValue <= cmd.interval;
    end
  end

  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.curWr) |=> $stable(curValue));
  p_step_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cmd.curWr && curValue != '0) |=> (curValue == $past(curValue) - 1'b1));
  p_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cmd.curWr && curValue == '0 && cmd.autoReload) |=> (curValue == $past(cmd.interval)));
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.curWr |=> (curValue == $past(cmd.curData)));
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PRESC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          irq,
  input  logic [DW-1:0] curValue,
  input  logic          expire,
  output ctrlToDp_t     cmd
);
  logic          ienBit;
  logic          pending;
  logic          runBit;
  logic          autoBit;
  logic          srcBit;
  logic [PW-1:0] divSel;
  logic [DW-1:0] interval;

  logic wrIen, wrStat, wrCtrl, wrIval, wrCur;

  assign wrIen  = busWe && (busAddr == OFS_IEN);
  assign wrStat = busWe && (busAddr == OFS_STAT);
  assign wrCtrl = busWe && (busAddr == OFS_CTRL);
  assign wrIval = busWe && (busAddr == OFS_IVAL);
  assign wrCur  = busWe && (busAddr == OFS_CUR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienBit   <= 1'b0;
      autoBit  <= 1'b0;
      srcBit   <= 1'b0;
      divSel   <= '0;
      interval <= '0;
    end else begin
      if (wrIen) ienBit <= busWdata[0];
      if (wrCtrl) begin
        autoBit <= busWdata[1];
        srcBit  <= busWdata[2];
        divSel  <= busWdata[4 +: PW];
      end
      if (wrIval) interval <= busWdata;
    end
  end

  // run bit: a software write wins over the hardware stop at one-shot expiry
  always_ff @(posedge clk) begin
    if (!rstN)                    runBit <= 1'b0;
    else if (wrCtrl)              runBit <= busWdata[0];
    else if (expire && !autoBit)  runBit <= 1'b0;
  end

  // pending: setting wins over clearing
  always_ff @(posedge clk) begin
    if (!rstN)                       pending <= 1'b0;
    else if (expire)                 pending <= 1'b1;
    else if (wrStat && busWdata[0])  pending <= 1'b0;
  end

  assign irq = pending && ienBit;

  always_comb begin
    cmd.run        = runBit;
    cmd.autoReload = autoBit;
    cmd.divSel     = divSel;
    cmd.prescClr   = wrCtrl;
    cmd.curWr      = wrCur;
    cmd.curData    = busWdata;
    cmd.interval   = interval;
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      OFS_IEN:  busRdata[0] = ienBit;
      OFS_STAT: busRdata[0] = pending;
      OFS_CTRL: begin
        busRdata[0]      = runBit;
        busRdata[1]      = autoBit;
        busRdata[2]      = srcBit;
        busRdata[4 +: PW] = divSel;
      end
      OFS_IVAL: busRdata = interval;
      OFS_CUR:  busRdata = curValue;
      default:  busRdata = '0;
    endcase
  end

  p_pending_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> pending);
  p_pending_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !(wrStat && busWdata[0])) |=> pending);
  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !autoBit && !wrCtrl) |=> !runBit);
  p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!ienBit && !wrIen) |=> !irq);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PRESC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          irq
);
  ctrlToDp_t     cmd;
  logic [DW-1:0] curValue;
  logic          expire;

  timer_ctrl #(.AW(AW), .DW(DW), .PW(PW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .curValue(curValue), .expire(expire), .cmd(cmd)
  );

  timer_datapath #(.DW(DW), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .curValue(curValue), .expire(expire)
  );
endmodule

// File: tb/reload_timer_tb.sv
module reload_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  reload_timer u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; commits on the next posedge, returns at the following negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    chk(req, busRdata, exp);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rdChk("R1 ien", 8'h00, 0);
    rdChk("R1 stat", 8'h04, 0);
    rdChk("R1 ctrl", 8'h10, 0);
    rdChk("R1 ival", 8'h14, 0);
    rdChk("R1 cur", 8'h18, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_regmap;
    wr(8'h10, 32'hFFFF_FF76);
    rdChk("R2 R13 ctrl readback", 8'h10, 32'h76);
    wr(8'h14, 32'h1234);
    rdChk("R2 ival", 8'h14, 32'h1234);
    wr(8'h00, 32'hFFFF_FFFE);
    rdChk("R2 ien bit0 only", 8'h00, 0);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(8'h08, 32'hFFFF_FFFF);
    rdChk("R3 unmapped read", 8'h08, 0);
    rdChk("R3 ival untouched", 8'h14, 32'h1234);
    rdChk("R3 ctrl untouched", 8'h10, 0);
    rdChk("R3 cur untouched", 8'h18, 0);
  endtask

  task automatic t_hold;
    wr(8'h18, 7);
    waitCyc(5);
    rdChk("R5 hold while stopped", 8'h18, 7);
  endtask

  task automatic t_oneshot;
    wr(8'h18, 5);
    wr(8'h10, 32'h5);           // run + source select, one-shot, /1
    waitCyc(4);
    rdChk("R5 R13 count at edge 4", 8'h18, 1);
    rdChk("R6 not yet pending", 8'h04, 0);
    waitCyc(1);
    rdChk("R6 zero at edge 5", 8'h18, 0);
    rdChk("R6 pending with irq disabled", 8'h04, 1);
    rdChk("R7 run cleared", 8'h10, 32'h4);
    chk("R11 irq masked", {31'b0, irq}, 0);
    waitCyc(3);
    rdChk("R7 stays at zero", 8'h18, 0);
    wr(8'h00, 1);
    chk("R11 irq enabled", {31'b0, irq}, 1);
    wr(8'h04, 1);
    rdChk("R10 pending cleared", 8'h04, 0);
    chk("R11 irq after clear", {31'b0, irq}, 0);
    wr(8'h00, 0);
  endtask

  task automatic t_presc;
    wr(8'h18, 2);
    wr(8'h10, 32'h21);          // run, exponent 2
    waitCyc(3);
    rdChk("R4 no step before edge 4", 8'h18, 2);
    waitCyc(1);
    rdChk("R4 step at edge 4", 8'h18, 1);
    waitCyc(3);
    rdChk("R4 no step before edge 8", 8'h18, 1);
    waitCyc(1);
    rdChk("R4 step at edge 8", 8'h18, 0);
    rdChk("R4 pending", 8'h04, 1);
    wr(8'h04, 1);
  endtask

  task automatic t_periodic;
    wr(8'h14, 3);
    wr(8'h18, 2);
    wr(8'h10, 32'h3);           // run, periodic, /1
    waitCyc(1);
    rdChk("R8 first from cur", 8'h18, 1);
    waitCyc(1);
    rdChk("R8 first expiry count", 8'h18, 0);
    rdChk("R8 first expiry pending", 8'h04, 1);
    wr(8'h04, 1);
    rdChk("R10 cleared", 8'h04, 0);
    rdChk("R8 reload interval", 8'h18, 3);
    waitCyc(2);
    wr(8'h04, 1);               // commits on the edge of the second expiry
    rdChk("R10 set wins over clear", 8'h04, 1);
    rdChk("R8 second expiry", 8'h18, 0);
    waitCyc(1);
    rdChk("R8 reload again", 8'h18, 3);
    rdChk("R8 still running", 8'h10, 3);
    // R12: drop periodic mid-run
    wr(8'h10, 32'h1);
    rdChk("R12 count after mode write", 8'h18, 2);
    wr(8'h04, 1);
    rdChk("R12 cleared", 8'h04, 0);
    rdChk("R12 count", 8'h18, 1);
    waitCyc(1);
    rdChk("R12 stop at next timeout", 8'h18, 0);
    rdChk("R12 run cleared", 8'h10, 0);
    rdChk("R12 pending", 8'h04, 1);
    waitCyc(2);
    rdChk("R12 stays stopped", 8'h18, 0);
  endtask

  task automatic t_rearm;
    wr(8'h04, 1);
    wr(8'h18, 4);
    wr(8'h10, 32'h3);
    waitCyc(1);
    rdChk("R12 rearm step", 8'h18, 3);
    waitCyc(3);
    rdChk("R12 rearm expiry", 8'h18, 0);
    rdChk("R12 rearm pending", 8'h04, 1);
    waitCyc(1);
    rdChk("R12 rearm reload", 8'h18, 3);
    wr(8'h18, 9);
    rdChk("R9 write beats tick", 8'h18, 9);
    waitCyc(1);
    rdChk("R9 counts from written", 8'h18, 8);
    rdChk("R9 interval unchanged", 8'h14, 3);
    wr(8'h10, 0);
    wr(8'h04, 1);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    t_reset();
    t_regmap();
    t_unmapped();
    t_hold();
    t_oneshot();
    t_presc();
    t_periodic();
    t_rearm();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule